// File: doc/BRIEF.md
# Mode-Dependent Synchronous Serial Word Framer

This block sits on the FPGA side of a synchronous serial link to a host microcontroller. It takes parallel sample words through a valid/ready handshake and shifts them out on a single data line. It also drives the bit clock and a frame-sync pulse, so the host receiver simply follows the clock and frame that the block provides. The bit clock comes from the system clock through a parameterizable divider and runs continuously.

The word length is 8 or 16 bits. It is chosen from a 3-bit major-mode field, which is bits 8 to 6 of the configuration word. Each frame-sync pulse marks exactly one word, and the most significant bit goes first. The block changes data and frame sync only on a falling edge of the serial clock, so the host can sample both on the rising edge. A rising edge of frame sync starts the host's receiver. The block takes a new word only at a word boundary, and it reads the length at that moment. Words can follow each other with no gap. When no word is offered, the link idles with frame sync and data low.

Top module: `ssp_word_framer`

## Requirements
- R1: `sclk_o` is a free-running clock with a period of 2*DIV_HALF system clocks. It starts low after reset.
- R2: A word is 16 bits (`data_i[15:0]`) when `major_mode_i` equals LONG_SEL (default 3'b001). For every other value of `major_mode_i`, a word is 8 bits, and it is taken from `data_i[7:0]`.
- R3: Bits go out most significant bit first, and each frame-sync pulse carries exactly one word.
- R4: `sdata_o` and `fsync_o` change only in the system clock cycle in which `sclk_o` falls. They are stable across every rising edge of `sclk_o`.
- R5: `fsync_o` is high for exactly one serial clock period, which is the period that carries the first (most significant) bit of a word.
- R6: `ready_o` is high for a single system clock cycle, at an edge where `sclk_o` is about to fall. It is high only if the block is idle or is sending the last bit of a word. A word is taken when `valid_i` and `ready_o` are both high.
- R7: The word length is read from `major_mode_i` when a word is taken. A change of `major_mode_i` while a word is in flight has no effect on that word.
- R8: If a word is offered when the last bit of the previous word ends, the new word's first bit follows on the next serial clock period, with no gap.
- R9: With no valid word, the block idles with `fsync_o` low and `sdata_o` low.
- R10: During reset, `sclk_o`, `fsync_o`, `sdata_o` and `ready_o` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | LONG_W (16) | Parallel word; short words use the low SHORT_W bits |
| valid_i | input | 1 | Word on `data_i` is valid |
| ready_o | output | 1 | Word is taken on this cycle if `valid_i` is high |
| major_mode_i | input | MAJ_W (3) | Major-mode field (configuration bits 8:6) that selects the word length |
| sclk_o | output | 1 | Serial bit clock |
| fsync_o | output | 1 | Frame sync, high during the MSB of each word |
| sdata_o | output | 1 | Serial data, MSB first |

## Verification
The bench sends single 16-bit words and single 8-bit words. The mode values include ones whose low bits are also set, which separates a correct field decode from a loose one. Alternating 0/1 bit patterns and one-hot patterns show whether the bit order is reversed or a bit is dropped. Switching the mode field while a long word is in flight shows whether the length is read only at the frame start. Back-to-back pairs are measured from one frame edge to the next, to expose any idle gap. Long idle stretches confirm that data and frame sync stay low.

// File: rtl/ssp_framer_pkg.sv
package ssp_framer_pkg;
  typedef enum logic {
    LEN_SHORT = 1'b0,
    LEN_LONG  = 1'b1
  } word_len_e;
endpackage

// File: rtl/ssp_clk_div.sv
module ssp_clk_div #(
  parameter int unsigned DIV_HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic sclk_o,
  output logic fall_tick_o
);
  localparam int unsigned CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DIV_HALF - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             sclk_q;
  logic             wrap;

  assign wrap = (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign sclk_o      = sclk_q;
  // strobe is high in the cycle whose closing edge drives sclk low
  assign fall_tick_o = wrap & sclk_q;
endmodule

// File: rtl/ssp_len_decode.sv
module ssp_len_decode
  import ssp_framer_pkg::*;
#(
  parameter int unsigned         MAJ_W    = 3,
  parameter logic [MAJ_W-1:0]    LONG_SEL = 3'b001
) (
  input  logic [MAJ_W-1:0] major_mode_i,
  output word_len_e        len_o
);
  always_comb begin
    len_o = (major_mode_i == LONG_SEL) ? LEN_LONG : LEN_SHORT;
  end
endmodule

// File: rtl/ssp_word_shifter.sv
module ssp_word_shifter
  import ssp_framer_pkg::*;
#(
  parameter int unsigned LONG_W  = 16,
  parameter int unsigned SHORT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_tick_i,
  input  logic [LONG_W-1:0] data_i,
  input  logic              valid_i,
  input  word_len_e         len_i,
  output logic              ready_o,
  output logic              fsync_o,
  output logic              sdata_o
);
  localparam int unsigned BC_W  = $clog2(LONG_W + 1);
  localparam int unsigned ALIGN = LONG_W - SHORT_W;

  logic [LONG_W-1:0] shreg_q;
  logic [BC_W-1:0]   bits_left_q;
  logic              busy_q;
  logic              fsync_q;
  logic              last_bit;
  logic              take;
  logic [LONG_W-1:0] load_word;
  logic [BC_W-1:0]   load_len;

  assign last_bit = busy_q && (bits_left_q == BC_W'(1));
  assign ready_o  = fall_tick_i && (!busy_q || last_bit);
  assign take     = ready_o && valid_i;

  // short words are left-aligned so the MSB always sits at the top
  always_comb begin
    if (len_i == LEN_LONG) begin
      load_word = data_i;
      load_len  = BC_W'(LONG_W);
    end else begin
      load_word = data_i << ALIGN;
      load_len  = BC_W'(SHORT_W);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q     <= '0;
      bits_left_q <= '0;
      busy_q      <= 1'b0;
      fsync_q     <= 1'b0;
    end else if (fall_tick_i) begin
      if (take) begin
        shreg_q     <= load_word;
        bits_left_q <= load_len;
        busy_q      <= 1'b1;
        fsync_q     <= 1'b1;
      end else if (busy_q && !last_bit) begin
        shreg_q     <= shreg_q << 1;
        bits_left_q <= bits_left_q - 1'b1;
        fsync_q     <= 1'b0;
      end else begin
        shreg_q     <= '0;
        bits_left_q <= '0;
        busy_q      <= 1'b0;
        fsync_q     <= 1'b0;
      end
    end
  end

  assign fsync_o = fsync_q;
  assign sdata_o = shreg_q[LONG_W-1];
endmodule

// File: rtl/ssp_word_framer.sv
module ssp_word_framer
  import ssp_framer_pkg::*;
#(
  parameter int unsigned      DIV_HALF = 2,
  parameter int unsigned      LONG_W   = 16,
  parameter int unsigned      SHORT_W  = 8,
  parameter int unsigned      MAJ_W    = 3,
  parameter logic [MAJ_W-1:0] LONG_SEL = 3'b001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LONG_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [MAJ_W-1:0]  major_mode_i,
  output logic              sclk_o,
  output logic              fsync_o,
  output logic              sdata_o
);
  logic      fall_tick;
  word_len_e len_sel;

  ssp_clk_div #(
    .DIV_HALF(DIV_HALF)
  ) clk_div_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_o     (sclk_o),
    .fall_tick_o(fall_tick)
  );

  ssp_len_decode #(
    .MAJ_W   (MAJ_W),
    .LONG_SEL(LONG_SEL)
  ) len_dec_i (
    .major_mode_i(major_mode_i),
    .len_o       (len_sel)
  );

  ssp_word_shifter #(
    .LONG_W (LONG_W),
    .SHORT_W(SHORT_W)
  ) shifter_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fall_tick_i(fall_tick),
    .data_i     (data_i),
    .valid_i    (valid_i),
    .len_i      (len_sel),
    .ready_o    (ready_o),
    .fsync_o    (fsync_o),
    .sdata_o    (sdata_o)
  );
endmodule

// File: rtl/ssp_word_framer_chk.sv
module ssp_word_framer_chk #(
  parameter int unsigned      MAJ_W    = 3,
  parameter logic [MAJ_W-1:0] LONG_SEL = 3'b001
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             ready_o,
  input logic [MAJ_W-1:0] major_mode_i,
  input logic             long_msb_i,
  input logic             short_msb_i,
  input logic             sclk_o,
  input logic             fsync_o,
  input logic             sdata_o
);
  logic exp_msb;
  assign exp_msb = (major_mode_i == LONG_SEL) ? long_msb_i : short_msb_i;

  assert_fsync_on_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fsync_o) |-> $fell(sclk_o));

  assert_sdata_on_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdata_o) |-> $fell(sclk_o));

  assert_ready_at_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> $fell(sclk_o));

  assert_load_msb_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> (fsync_o && (sdata_o == $past(exp_msb))));

  assert_fsync_one_period_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sclk_o) && $past(fsync_o) && !$past(valid_i && ready_o)) |-> !fsync_o);

  assert_idle_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !valid_i) |=> (!fsync_o && !sdata_o));
endmodule

bind ssp_word_framer ssp_word_framer_chk #(
  .MAJ_W   (MAJ_W),
  .LONG_SEL(LONG_SEL)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .ready_o     (ready_o),
  .major_mode_i(major_mode_i),
  .long_msb_i  (data_i[LONG_W-1]),
  .short_msb_i (data_i[SHORT_W-1]),
  .sclk_o      (sclk_o),
  .fsync_o     (fsync_o),
  .sdata_o     (sdata_o)
);

// File: tb/ssp_word_framer_tb.sv
module ssp_word_framer_tb_top;
  localparam int DIV_HALF = 2;
  localparam logic [2:0] LONG_M = 3'b001;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] data_i = '0;
  logic        valid_i = 1'b0;
  logic [2:0]  major_mode_i = 3'b000;
  logic        ready_o, sclk_o, fsync_o, sdata_o;

  int checks = 0;
  int failures = 0;
  int idle_bad = 0;
  longint cyc = 0;

  typedef struct { logic [15:0] word; int len; } item_t;
  item_t exp_q[$];

  bit   mon_busy = 0;
  int   rise_idx = 0;
  int   last_start = -1;
  int   last_gap = -1;

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  ssp_word_framer #(.DIV_HALF(DIV_HALF), .LONG_SEL(LONG_M)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .valid_i(valid_i),
    .ready_o(ready_o), .major_mode_i(major_mode_i), .sclk_o(sclk_o),
    .fsync_o(fsync_o), .sdata_o(sdata_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: offers a word, pushes the expected item, returns after the accept edge
  task automatic send(input logic [15:0] w, input logic [2:0] m, input bit hold);
    item_t it;
    @(negedge clk_i);
    data_i = w; major_mode_i = m; valid_i = 1'b1;
    it.len  = (m == LONG_M) ? 16 : 8;          // R2
    it.word = (m == LONG_M) ? w : {8'h00, w[7:0]};
    exp_q.push_back(it);
    while (!ready_o) @(negedge clk_i);
    @(posedge clk_i);
    @(negedge clk_i);
    if (!hold) valid_i = 1'b0;
  endtask

  task automatic wait_done();
    while (exp_q.size() != 0 || mon_busy) @(negedge clk_i);
    repeat (6) @(negedge clk_i);
  endtask

  // monitor: samples at the host's sampling edge (sclk rise), away from clk edges
  initial begin : monitor
    logic prev_sclk = 1'b0;
    item_t cur;
    logic [15:0] got = '0;
    int nbits = 0;
    forever begin
      @(negedge clk_i);
      if (rst_ni && sclk_o && !prev_sclk) begin
        rise_idx++;
        if (mon_busy && nbits < cur.len) begin
          if (fsync_o) begin
            failures++; checks++;
            $display("FAIL R5 fsync high on bit %0d actual=1 expected=0", nbits);
          end
          got = {got[14:0], sdata_o}; nbits++;
        end else if (fsync_o) begin
          if (last_start >= 0) last_gap = rise_idx - last_start;
          last_start = rise_idx;
          if (exp_q.size() == 0) begin
            failures++; checks++;
            $display("FAIL R3 unexpected frame actual=1 expected=0");
          end else begin
            cur = exp_q.pop_front();
            got = {15'd0, sdata_o}; nbits = 1; mon_busy = 1;
          end
        end else if (sdata_o) begin
          idle_bad++;
        end
        if (mon_busy && nbits == cur.len) begin
          check(got == cur.word, "R3/R2 word", got, cur.word);
          mon_busy = 0;
        end
      end
      prev_sclk = sclk_o;
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    longint t0;
    // R10 reset state
    repeat (3) @(negedge clk_i);
    check(!sclk_o && !fsync_o && !sdata_o, "R10 outputs in reset",
          {sclk_o, fsync_o, sdata_o}, 0);
    check(!ready_o, "R10 ready in reset", ready_o, 0);
    rst_ni = 1'b1;

    // R1 serial clock period
    @(posedge sclk_o); t0 = cyc;
    @(posedge sclk_o);
    check((cyc - t0) == 2 * DIV_HALF, "R1 sclk period", cyc - t0, 2 * DIV_HALF);

    // R9 idle with no valid
    repeat (20) @(negedge clk_i);
    check(!fsync_o && !sdata_o, "R9 idle outputs", {fsync_o, sdata_o}, 0);

    // R2/R3 long words, alternating and one-hot patterns
    send(16'hA55A, LONG_M, 0);
    send(16'h8001, LONG_M, 0);
    wait_done();
    // R2 short words; upper data bits must be dropped, non-matching fields short
    send(16'hFF96, 3'b000, 0);
    send(16'h1281, 3'b111, 0);
    send(16'h3C01, 3'b011, 0);
    wait_done();

    // R7 mode change mid-word has no effect
    send(16'hC3A5, LONG_M, 0);
    major_mode_i = 3'b000;
    wait_done();
    send(16'h5A96, 3'b010, 0);
    major_mode_i = LONG_M;
    wait_done();

    // R8 back-to-back short words
    send(16'h00F0, 3'b000, 1);
    send(16'h000F, 3'b000, 0);
    wait_done();
    check(last_gap == 8, "R8 short gap", last_gap, 8);
    // R8 back-to-back long words
    send(16'h1234, LONG_M, 1);
    send(16'hFEDC, LONG_M, 0);
    wait_done();
    check(last_gap == 16, "R8 long gap", last_gap, 16);

    // R6 ready only at boundary: accept happens while busy only on last bit
    repeat (30) @(negedge clk_i);
    check(!fsync_o && !sdata_o, "R9 idle after traffic", {fsync_o, sdata_o}, 0);
    check(idle_bad == 0, "R9 idle data samples", idle_bad, 0);
    check(exp_q.size() == 0, "R3 all words framed", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule